// File: doc/BRIEF.md
# DMA request generator channel

This block is one channel of a DMA request generator. It watches one of 32 external trigger lines, picked by a select field. Each trigger line passes through a synchronizer. On a chosen edge of the selected line, the channel sends a programmed burst of DMA requests over a request/acknowledge handshake. Only one request is outstanding at a time. It stays asserted until the DMA engine acknowledges it, and the next request follows only after that.

Software configures the channel through a small write port with two targets: a configuration word and a flag-clear word. If a qualifying trigger arrives while a burst is still running, the channel does not start a second burst. It sets a sticky overrun flag instead and drops that trigger. The flag drives a level-sensitive interrupt when the interrupt enable is set. Clearing the enable bit stops the channel at once: any burst in progress is abandoned and the request line falls.

Top module: `dma_trig_gen`

## Requirements
- R1: The select field (config bits [4:0]) chooses which bit of `trig_in` drives the channel. Edges on any other bit produce no requests.
- R2: The edge field (config bits [6:5]) sets detection. 00 detects nothing, 01 detects rising edges, 10 detects falling edges, 11 detects both edges.
- R3: The count field (config bits [13:9]) holds a value N. Each detected trigger produces exactly N+1 requests, so a burst is 1 to 32 requests.
- R4: A request is held asserted until `dma_ack` is sampled high with it. An acknowledge consumes exactly one request.
- R5: While the enable bit (config bit 7) is 0, no triggers are detected and `dma_req` stays low. The enable bit resets to 0.
- R6: A configuration write updates the count field only if the channel was disabled before that write. While the channel is enabled, the count field of a write is ignored.
- R7: A qualifying edge that arrives during a burst sets the overrun flag and is discarded. The running burst keeps its original length.
- R8: `irq` is high exactly while the overrun flag is set and the interrupt-enable bit (config bit 8) is 1.
- R9: A flag-clear write (`wr_sel`=1) with data bit 0 set to 1 clears the overrun flag. With bit 0 at 0 the write has no effect, and without a clear the flag stays set.
- R10: A configuration write that clears the enable bit abandons any burst in progress. `dma_req` is low from the same clock edge that clears the enable.
- R11: After the acknowledge of the last request of a burst, `dma_req` goes low. No further request follows without a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | Write target: 0 = configuration word, 1 = flag-clear word |
| wr_data | input | 14 | Write data |
| trig_in | input | 32 | Asynchronous trigger inputs |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |
| irq | output | 1 | Overrun interrupt, level-sensitive |

## Verification
The bench runs the full range of count values and every select value. Getting the count wrong by one, such as producing N instead of N+1 requests, would show up as a burst that is one request short or long. Each select value is also tested against a non-selected neighbour line, so a wrong mux index would produce requests from the wrong line.

All four edge codes are driven with both a rising and a falling edge. A design that treats 00 as a real edge code, or swaps the rise and fall codes, would give the wrong request total. A count write issued while the channel is enabled must leave the burst length unchanged.

The overrun case retriggers during a stalled burst. A design that queues the second trigger would produce eight requests instead of four. A design that fails to latch the flag would never raise `irq`. The abort case disables the channel mid-burst. A design that kept its busy state would resume requests after being re-enabled.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int SEL_W    = 5;
    localparam int CNT_W    = 5;
    localparam int NUM_TRIG = 1 << SEL_W;

    localparam int SEL_LSB  = 0;
    localparam int MODE_LSB = SEL_LSB + SEL_W;
    localparam int EN_BIT   = MODE_LSB + 2;
    localparam int OIE_BIT  = EN_BIT + 1;
    localparam int CNT_LSB  = OIE_BIT + 1;
    localparam int WR_W     = CNT_LSB + CNT_W;
    localparam int CLR_BIT  = 0;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             oie;
        logic             en;
        edge_mode_e       mode;
        logic [SEL_W-1:0] sel;
    } cfg_t;
endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [WR_W-1:0] wr_data,
    output cfg_t            cfg,
    output logic            clr_pulse
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !wr_sel) begin
            cfg_d.sel  = wr_data[SEL_LSB +: SEL_W];
            cfg_d.mode = edge_mode_e'(wr_data[MODE_LSB +: 2]);
            cfg_d.en   = wr_data[EN_BIT];
            cfg_d.oie  = wr_data[OIE_BIT];
            // burst length is frozen while the channel runs
            if (!cfg_q.en) begin
                cfg_d.cnt = wr_data[CNT_LSB +: CNT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg       = cfg_q;
    assign clr_pulse = wr_en && wr_sel && wr_data[CLR_BIT];
endmodule

// File: rtl/dtg_trig_detect.sv
module dtg_trig_detect
    import dtg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    sel,
    input  edge_mode_e          mode,
    input  logic                en,
    output logic                evt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_TRIG-1:0] sync;
        logic                                 prev;
    } det_t;

    det_t st_d, st_q;
    logic cur, rise, fall;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = trig_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        cur       = st_q.sync[SYNC_STAGES-1][sel];
        st_d.prev = cur;
        rise      = cur && !st_q.prev;
        fall      = !cur && st_q.prev;
        evt       = en && ((mode[0] && rise) || (mode[1] && fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dtg_burst_ctrl.sv
module dtg_burst_ctrl
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             oie,
    input  logic [CNT_W-1:0] cnt_cfg,
    input  logic             evt,
    input  logic             clr,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             irq,
    output logic             busy,
    output logic [CNT_W-1:0] rem,
    output logic             ovr
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] rem;
        logic             ovr;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && dma_ack) begin
            if (st_q.rem == '0) st_d.busy = 1'b0;
            else                st_d.rem  = st_q.rem - 1'b1;
        end
        if (clr) st_d.ovr = 1'b0;
        if (evt) begin
            if (st_q.busy) begin
                st_d.ovr = 1'b1;          // set beats a same-cycle clear
            end else begin
                st_d.busy = 1'b1;
                st_d.rem  = cnt_cfg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dma_req = st_q.busy && en;
    assign irq     = st_q.ovr && oie;
    assign busy    = st_q.busy;
    assign rem     = st_q.rem;
    assign ovr     = st_q.ovr;
endmodule

// File: rtl/dma_trig_gen.sv
module dma_trig_gen
    import dtg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WR_W-1:0]     wr_data,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic                dma_req,
    input  logic                dma_ack,
    output logic                irq
);
    cfg_t             cfg;
    logic             flag_clr;
    logic             trig_evt;
    logic             busy;
    logic [CNT_W-1:0] rem;
    logic             ovr_flag;

    dtg_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .clr_pulse (flag_clr)
    );

    dtg_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (cfg.sel),
        .mode    (cfg.mode),
        .en      (cfg.en),
        .evt     (trig_evt)
    );

    dtg_burst_ctrl u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.en),
        .oie     (cfg.oie),
        .cnt_cfg (cfg.cnt),
        .evt     (trig_evt),
        .clr     (flag_clr),
        .dma_ack (dma_ack),
        .dma_req (dma_req),
        .irq     (irq),
        .busy    (busy),
        .rem     (rem),
        .ovr     (ovr_flag)
    );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dis_wr,
    input logic             dma_req,
    input logic             dma_ack,
    input logic             cfg_en,
    input logic [CNT_W-1:0] cnt_cfg,
    input logic             busy,
    input logic [CNT_W-1:0] rem,
    input logic             ovr_flag,
    input logic             flag_clr
);
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !dis_wr) |=> dma_req);

    a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy);

    a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(cnt_cfg));

    a_r7_flag_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(busy));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !flag_clr) |=> ovr_flag);

    a_r10_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |-> !dma_req);

    a_r11_last_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && rem == '0) |=> !dma_req);
endmodule

bind dma_trig_gen dtg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis_wr   (wr_en && !wr_sel && !wr_data[dtg_pkg::EN_BIT]),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack),
    .cfg_en   (cfg.en),
    .cnt_cfg  (cfg.cnt),
    .busy     (busy),
    .rem      (rem),
    .ovr_flag (ovr_flag),
    .flag_clr (flag_clr)
);

// File: tb/tb_dma_trig_gen.sv
module tb_dma_trig_gen;
    import dtg_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic                wr_sel = 1'b0;
    logic [WR_W-1:0]     wr_data = '0;
    logic [NUM_TRIG-1:0] trig = '0;
    logic                dma_ack = 1'b0;
    logic                dma_req, irq;

    int checks = 0;
    int errors = 0;
    int ack_cnt = 0;
    bit auto_ack = 1'b1;

    always #5 clk = ~clk;

    dma_trig_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .trig_in(trig), .dma_req(dma_req),
        .dma_ack(dma_ack), .irq(irq)
    );

    // acknowledge side: one acknowledge per observed request cycle
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && dma_req) begin
                dma_ack = 1'b1;
                ack_cnt++;
            end else begin
                dma_ack = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int sel, input int mode, input bit en,
                             input bit oie, input int cnt);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0;
        wr_data = '0;
        wr_data[SEL_LSB +: SEL_W]  = sel[SEL_W-1:0];
        wr_data[MODE_LSB +: 2]     = mode[1:0];
        wr_data[EN_BIT]            = en;
        wr_data[OIE_BIT]           = oie;
        wr_data[CNT_LSB +: CNT_W]  = cnt[CNT_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_clr(input bit b);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = '0; wr_data[CLR_BIT] = b;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0;
    endtask

    // rise then fall on one line; count requests granted in total
    task automatic pulse_count(input int idx, input int exp, input string tag);
        ack_cnt = 0;
        @(negedge clk); trig[idx] = 1'b1;
        idle(50);
        @(negedge clk); trig[idx] = 1'b0;
        idle(50);
        check(tag, ack_cnt, exp);
        check({tag, " req idle after burst"}, int'(dma_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R5 reset req", int'(dma_req), 0);
        check("R8 reset irq", int'(irq), 0);

        // R3 + R11: every count value, rising edges
        for (int n = 0; n < 32; n++) begin
            write_cfg(3, 1, 1'b0, 1'b0, n);
            write_cfg(3, 1, 1'b1, 1'b0, n);
            pulse_count(3, n + 1, $sformatf("R3 count %0d", n));
        end

        // R1: every select value, selected vs neighbouring line
        for (int s = 0; s < 32; s++) begin
            write_cfg(s, 1, 1'b0, 1'b0, 1);
            write_cfg(s, 1, 1'b1, 1'b0, 1);
            pulse_count(s, 2, $sformatf("R1 selected %0d", s));
            pulse_count((s + 1) % 32, 0, $sformatf("R1 other line for %0d", s));
        end

        // R2: each edge code with one rise and one fall (3 requests per edge)
        for (int m = 0; m < 4; m++) begin
            write_cfg(5, m, 1'b0, 1'b0, 2);
            write_cfg(5, m, 1'b1, 1'b0, 2);
            pulse_count(5, ((m & 1) ? 3 : 0) + ((m & 2) ? 3 : 0),
                        $sformatf("R2 edge code %0d", m));
        end

        // R5: disabled channel ignores edges
        write_cfg(5, 1, 1'b0, 1'b0, 2);
        pulse_count(5, 0, "R5 disabled");

        // R6: count write while enabled is ignored, while disabled it takes
        write_cfg(5, 1, 1'b1, 1'b0, 2);
        write_cfg(5, 1, 1'b1, 1'b0, 7);
        pulse_count(5, 3, "R6 count held while enabled");
        write_cfg(5, 1, 1'b0, 1'b0, 7);
        write_cfg(5, 1, 1'b1, 1'b0, 7);
        pulse_count(5, 8, "R6 count taken while disabled");

        // R4 + R7: stall the burst, retrigger
        write_cfg(5, 1, 1'b0, 1'b1, 3);
        write_cfg(5, 1, 1'b1, 1'b1, 3);
        auto_ack = 1'b0;
        ack_cnt = 0;
        @(negedge clk); trig[5] = 1'b1;
        idle(6);
        check("R4 request raised", int'(dma_req), 1);
        check("R7 no flag before retrigger", int'(irq), 0);
        @(negedge clk); trig[5] = 1'b0;
        idle(4);
        @(negedge clk); trig[5] = 1'b1;
        idle(6);
        check("R7 overrun flagged", int'(irq), 1);
        idle(20);
        check("R4 request held without ack", int'(dma_req), 1);
        auto_ack = 1'b1;
        idle(30);
        check("R7 retrigger discarded", ack_cnt, 4);

        // R8: mask and unmask the held flag
        write_cfg(5, 1, 1'b1, 1'b0, 3);
        idle(1);
        check("R8 masked", int'(irq), 0);
        write_cfg(5, 1, 1'b1, 1'b1, 3);
        idle(1);
        check("R8 unmasked", int'(irq), 1);

        // R9: clear with 0 has no effect, with 1 clears
        write_clr(1'b0);
        idle(1);
        check("R9 clear bit 0 ignored", int'(irq), 1);
        write_clr(1'b1);
        idle(1);
        check("R9 clear bit 1", int'(irq), 0);
        @(negedge clk); trig[5] = 1'b0;
        idle(10);

        // R10: abort mid-burst
        ack_cnt = 0;
        auto_ack = 1'b0;
        @(negedge clk); trig[5] = 1'b1;
        idle(6);
        check("R10 burst running", int'(dma_req), 1);
        write_cfg(5, 1, 1'b0, 1'b1, 3);
        check("R10 req dropped with enable", int'(dma_req), 0);
        write_cfg(5, 1, 1'b1, 1'b1, 3);
        auto_ack = 1'b1;
        idle(30);
        check("R10 no resume after re-enable", ack_cnt, 0);
        check("R10 no overrun from abort", int'(irq), 0);
        @(negedge clk); trig[5] = 1'b0;
        idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule